// File: doc/BRIEF.md
# I2C Indexed Register Bridge

This block is a two-wire serial bus slave that gives a host controller access to a small set of control registers and two byte arrays through a single index. A write message names the target in its first byte after the address (the index) and may carry data bytes after it. A read message carries no index and returns data from wherever the last written index points. The repeated-START form, an index write followed directly by a read, is supported. Plain registers are reached directly by index. The RAM and the EEPROM-style array are reached indirectly: the host loads a pointer register, then moves bytes through a data-port index.

The block never starts a transfer. Internal events are latched in a status register and signalled on an active-high interrupt line, so the host reads status only when told to.

The protocol engine is a state machine with seven states. `S_IDLE` waits for START. `S_ADDR` shifts in the address byte. `S_AACK` acknowledges a matching address. `S_RX` receives index or data bytes. `S_WACK` acknowledges each received byte. `S_TX` shifts a byte out. `S_RACK` samples the host's acknowledge. The transitions are as follows:
- START moves any state to `S_ADDR`.
- STOP moves any state to `S_IDLE`.
- `S_ADDR` goes to `S_AACK` on a match, or to `S_IDLE` on a mismatch.
- `S_AACK` goes to `S_RX` for a write or to `S_TX` for a read.
- `S_RX` goes to `S_WACK`, and `S_WACK` returns to `S_RX`.
- `S_TX` goes to `S_RACK`.
- `S_RACK` returns to `S_TX` on ACK, or goes to `S_IDLE` on NACK.

Top module: `i2c_index_bridge`

## Requirements
- R1: SCL and SDA pass through a two-stage synchroniser. SDA falling while SCL is high (START) moves the engine from any state to address reception. SDA rising while SCL is high (STOP) returns it to idle with SDA released on the next clock.
- R2: The 7-bit address (default 0x2A, so 0x54 for write and 0x55 for read) is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that message is ignored until the next START.
- R3: In a write message, the first byte after the address is stored as the index and later bytes are data. The slave acknowledges every byte.
- R4: A read message returns bytes starting from the most recently written index. The index may be written in a write message closed by STOP, or in a write followed by a repeated START and the read address.
- R5: Index map: 0x00 identity (reads 0xA5), 0x01 scratch read/write, 0x02 trigger, 0x03 event status, 0x04 RAM pointer, 0x05 RAM data port, 0x06 array pointer, 0x07 array data port; indices 0x08 and above read 0x00 and ignore writes. For every index except 0x05 and 0x07, the index increases by one after each data byte written or read.
- R6: The RAM pointer occupies bits [3:0] of index 0x04. Each byte written or read through 0x05 advances the pointer by one modulo 16, and the index stays at 0x05.
- R7: Index 0x06 holds the array row in bits [5:4] and the column in bits [2:0]. Each byte through index 0x07 advances the column from 0 to 5. After column 5 it moves to column 0 of the next row, and row 3 wraps to row 0. The index stays at 0x07.
- R8: Writes to the identity register and to the status register have no effect.
- R9: Writing a byte with bit 0 set to the trigger index sets status bit 3. A read of the trigger index returns an undefined value.
- R10: An event input ev_i[k] high in a clock cycle sets status bit k (k = 0..2). int_o is high from the next cycle for as long as any status bit is set.
- R11: Reading the status register returns its current value, then clears it and drops int_o. An event arriving in the very cycle of that read stays latched and keeps int_o high.
- R12: When the host NACKs a read byte, the slave releases SDA and drives nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls the open-drain SDA pad low |
| ev_i | input | 3 | Internal event strobes, one per status bit |
| int_o | output | 1 | Active-high interrupt, high while any status bit is set |

## Verification
The status register can be read and cleared in the same clock in which a new event strobe arrives. The clear must not swallow that event. The bench lines up a one-cycle event pulse with the exact clock in which the byte is fetched: the third clock edge after the SCL fall that ends the read-address acknowledge, counting the two synchroniser stages and the edge detector. The check passes when the returned byte holds only the older bits, int_o stays high afterwards, and a second status read returns only the new bit.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
package i2cb_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_RX, S_WACK, S_TX, S_RACK
    } bus_state_e;

    localparam logic [7:0] IX_ID   = 8'h00;
    localparam logic [7:0] IX_SCR  = 8'h01;
    localparam logic [7:0] IX_TRIG = 8'h02;
    localparam logic [7:0] IX_STAT = 8'h03;
    localparam logic [7:0] IX_RPTR = 8'h04;
    localparam logic [7:0] IX_RDAT = 8'h05;
    localparam logic [7:0] IX_EPTR = 8'h06;
    localparam logic [7:0] IX_EDAT = 8'h07;
endpackage

// File: rtl/i2cb_line_sync.sv
`timescale 1ns/1ps
module i2cb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    logic [1:0] pin_in;
    logic [1:0] now_v;
    logic [1:0] prev_v;

    assign pin_in = {scl_i, sda_i};

    // one synchroniser chain per line; the extra stage holds the previous value
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [DEPTH-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[DEPTH-2:0], pin_in[g]};
        end
        assign now_v[g]  = chain[STAGES-1];
        assign prev_v[g] = chain[STAGES];
    end

    assign scl_s     = now_v[1];
    assign sda_s     = now_v[0];
    assign scl_rise  = now_v[1] & ~prev_v[1];
    assign scl_fall  = ~now_v[1] & prev_v[1];
    assign start_det = now_v[1] & prev_v[1] & prev_v[0] & ~now_v[0];
    assign stop_det  = now_v[1] & prev_v[1] & ~prev_v[0] & now_v[0];
endmodule

// File: rtl/i2cb_reg_bank.sv
`timescale 1ns/1ps
module i2cb_reg_bank
    import i2cb_pkg::*;
#(
    parameter logic [7:0] ID_VALUE  = 8'hA5,
    parameter int         RAM_DEPTH = 16,
    parameter int         EE_ROWS   = 4,
    parameter int         EE_COLS   = 6,
    parameter int         NUM_EV    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic              rd_fetch,
    input  logic [7:0]        rx_byte,
    input  logic [NUM_EV-1:0] ev_i,
    output logic [7:0]        rd_byte,
    output logic              int_o
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam int EE_RW  = $clog2(EE_ROWS);
    localparam int EE_CW  = $clog2(EE_COLS);
    localparam int EE_N   = EE_ROWS * EE_COLS;
    localparam int EE_AW  = $clog2(EE_N);

    logic [7:0]        index;
    logic [7:0]        scratch;
    logic [NUM_EV:0]   status;
    logic [RAM_AW-1:0] ram_ptr;
    logic [EE_RW-1:0]  ee_row;
    logic [EE_CW-1:0]  ee_col;
    logic [7:0]        ram_mem [RAM_DEPTH];
    logic [7:0]        ee_mem  [EE_N];

    logic              is_port, xfer, ee_valid, sw_ev, stat_clr;
    logic [EE_AW-1:0]  ee_addr;
    logic [7:0]        ee_ptr_rd;

    always_comb begin
        is_port   = (index == IX_RDAT) || (index == IX_EDAT);
        xfer      = dat_wr || rd_fetch;
        ee_valid  = int'(ee_col) < EE_COLS;
        ee_addr   = EE_AW'(int'(ee_row) * EE_COLS + int'(ee_col));
        ee_ptr_rd = 8'(ee_col) | (8'(ee_row) << 4);
        sw_ev     = dat_wr && (index == IX_TRIG) && rx_byte[0];
        stat_clr  = rd_fetch && (index == IX_STAT);
    end

    always_comb begin
        case (index)
            IX_ID:   rd_byte = ID_VALUE;
            IX_SCR:  rd_byte = scratch;
            IX_STAT: rd_byte = 8'(status);
            IX_RPTR: rd_byte = 8'(ram_ptr);
            IX_RDAT: rd_byte = ram_mem[ram_ptr];
            IX_EPTR: rd_byte = ee_ptr_rd;
            IX_EDAT: rd_byte = ee_valid ? ee_mem[ee_addr] : 8'h00;
            default: rd_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index   <= '0;
            scratch <= '0;
            status  <= '0;
            ram_ptr <= '0;
            ee_row  <= '0;
            ee_col  <= '0;
        end else begin
            status <= (stat_clr ? '0 : status) | {sw_ev, ev_i};
            if (idx_wr) begin
                index <= rx_byte;
            end else if (xfer) begin
                if (!is_port) index <= index + 8'd1;
                if (dat_wr && index == IX_SCR)  scratch <= rx_byte;
                if (dat_wr && index == IX_RPTR) ram_ptr <= rx_byte[RAM_AW-1:0];
                if (dat_wr && index == IX_EPTR) begin
                    ee_col <= rx_byte[EE_CW-1:0];
                    ee_row <= rx_byte[4 +: EE_RW];
                end
                if (index == IX_RDAT) ram_ptr <= ram_ptr + 1'b1;
                if (index == IX_EDAT) begin
                    if (ee_col == EE_CW'(EE_COLS - 1)) begin
                        ee_col <= '0;
                        ee_row <= (ee_row == EE_RW'(EE_ROWS - 1)) ? '0 : ee_row + 1'b1;
                    end else begin
                        ee_col <= ee_col + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (dat_wr && index == IX_RDAT) ram_mem[ram_ptr] <= rx_byte;
        if (dat_wr && index == IX_EDAT && ee_valid) ee_mem[ee_addr] <= rx_byte;
    end

    assign int_o = |status;

    assert_port_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !idx_wr && is_port) |=> (index == $past(index)));
    assert_ram_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !idx_wr && index == IX_RDAT) |=> (ram_ptr == $past(ram_ptr) + 1'b1));
    assert_ee_col_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !idx_wr && index == IX_EDAT && ee_col == EE_CW'(EE_COLS - 1)) |=> (ee_col == '0));
    assert_event_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> int_o);
    assert_clear_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(|ev_i) && !sw_ev) |=> !int_o);
endmodule

// File: rtl/i2c_index_bridge.sv
`timescale 1ns/1ps
module i2c_index_bridge
    import i2cb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h2A,
    parameter logic [7:0] ID_VALUE   = 8'hA5,
    parameter int         RAM_DEPTH  = 16,
    parameter int         EE_ROWS    = 4,
    parameter int         EE_COLS    = 6,
    parameter int         NUM_EV     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [NUM_EV-1:0] ev_i,
    output logic              int_o
);
    bus_state_e state;
    logic [7:0] shreg, txsh, rd_byte;
    logic [3:0] bcnt;
    logic       rw, first_byte;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       byte_done, idx_wr, dat_wr, rd_fetch;

    i2cb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cb_reg_bank #(
        .ID_VALUE(ID_VALUE), .RAM_DEPTH(RAM_DEPTH), .EE_ROWS(EE_ROWS),
        .EE_COLS(EE_COLS), .NUM_EV(NUM_EV)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
        .rd_fetch(rd_fetch), .rx_byte(shreg), .ev_i(ev_i),
        .rd_byte(rd_byte), .int_o(int_o)
    );

    assign byte_done = (bcnt == 4'd8) && scl_fall;

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            shreg      <= '0;
            txsh       <= '0;
            bcnt       <= '0;
            rw         <= 1'b0;
            first_byte <= 1'b0;
        end else if (start_det) begin
            state <= S_ADDR;
            bcnt  <= '0;
        end else if (stop_det) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_ADDR, S_RX: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        bcnt  <= bcnt + 4'd1;
                    end else if (byte_done) begin
                        if (state == S_RX) begin
                            state      <= S_WACK;
                            first_byte <= 1'b0;
                        end else if (shreg[7:1] == SLAVE_ADDR) begin
                            rw    <= shreg[0];
                            state <= S_AACK;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                S_AACK: if (scl_fall) begin
                    bcnt <= '0;
                    if (rw) begin
                        txsh  <= rd_byte;
                        state <= S_TX;
                    end else begin
                        first_byte <= 1'b1;
                        state      <= S_RX;
                    end
                end
                S_WACK: if (scl_fall) begin
                    bcnt  <= '0;
                    state <= S_RX;
                end
                S_TX: if (scl_fall) begin
                    if (bcnt == 4'd7) begin
                        bcnt  <= '0;
                        state <= S_RACK;
                    end else begin
                        txsh <= {txsh[6:0], 1'b0};
                        bcnt <= bcnt + 4'd1;
                    end
                end
                S_RACK: begin
                    if (scl_rise && sda_s) begin
                        state <= S_IDLE;
                    end else if (scl_fall) begin
                        txsh  <= rd_byte;
                        bcnt  <= '0;
                        state <= S_TX;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs and strobes
    always_comb begin
        sda_oe_o = (state == S_AACK) || (state == S_WACK) || (state == S_TX && !txsh[7]);
        idx_wr   = (state == S_RX) && byte_done && first_byte;
        dat_wr   = (state == S_RX) && byte_done && !first_byte;
        rd_fetch = ((state == S_AACK) && rw && scl_fall) || ((state == S_RACK) && scl_fall);
    end

    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR));
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE && !sda_oe_o));
    assert_mismatch_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && byte_done && shreg[7:1] != SLAVE_ADDR && !start_det && !stop_det)
        |=> !sda_oe_o);
    assert_nack_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK && scl_rise && sda_s && !start_det && !stop_det) |=> !sda_oe_o);
endmodule

// File: tb/i2c_index_bridge_bench.sv
`timescale 1ns/1ps
module i2c_index_bridge_bench;
    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h54;
    localparam logic [7:0] AR = 8'h55;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] ev = 3'b000;
    logic sda_oe, int_o;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_index_bridge u_i2c_index_bridge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .ev_i(ev), .int_o(int_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    // evm: event strobe placed on the third clock edge after SCL falls
    task automatic recv_bit(output logic b, input logic [2:0] evm);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        b = sda_line; tick(Q); scl = 1'b0;
        if (evm != 3'b000) begin
            tick(2); ev = evm; tick(1); ev = 3'b000; tick(Q - 3);
        end else begin
            tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [2:0] evm, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a, evm);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic last);
        logic x;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(x, 3'b000);
            b = {b[6:0], x};
        end
        send_bit(last);
    endtask

    task automatic wr_regs(input logic [7:0] idx, input int n, input logic [7:0] d [0:3],
                           input string req);
        logic ack;
        bus_start();
        send_byte(AW, 3'b000, ack);  chk({req, " addr ack"}, 8'(ack), 8'h01);
        send_byte(idx, 3'b000, ack); chk({req, " index ack"}, 8'(ack), 8'h01);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], 3'b000, ack);
            chk({req, " data ack"}, 8'(ack), 8'h01);
        end
        bus_stop();
    endtask

    task automatic rd_regs(input logic [7:0] idx, input int n, input logic [2:0] evm,
                           output logic [7:0] d [0:3]);
        logic ack;
        bus_start();
        send_byte(AW, 3'b000, ack);
        send_byte(idx, 3'b000, ack);
        bus_start();
        send_byte(AR, evm, ack);
        for (int i = 0; i < n; i++) recv_byte(d[i], i == n - 1);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R10 reset int_o", 8'(int_o), 8'h00);
        chk("R1 reset sda released", 8'(sda_line), 8'h01);
    endtask

    task automatic t_write_burst();
        logic [7:0] d [0:3];
        wr_regs(8'h01, 2, '{8'h3C, 8'h00, 8'h00, 8'h00}, "R3");
        rd_regs(8'h00, 3, 3'b000, d);
        chk("R5 id", d[0], 8'hA5);
        chk("R5 scratch via increment", d[1], 8'h3C);
        chk("R9 trigger bit0=0 no event", 8'(int_o), 8'h00);
        rd_regs(8'h09, 1, 3'b000, d);
        chk("R5 unmapped reads zero", d[0], 8'h00);
    endtask

    task automatic t_read_last_index();
        logic [7:0] d [0:3];
        logic ack;
        wr_regs(8'h01, 0, '{8'h00, 8'h00, 8'h00, 8'h00}, "R4");
        bus_start();
        send_byte(AR, 3'b000, ack);
        chk("R4 read addr ack", 8'(ack), 8'h01);
        recv_byte(d[0], 1'b1);
        bus_stop();
        chk("R4 read from last index", d[0], 8'h3C);
    endtask

    task automatic t_read_only_id();
        logic [7:0] d [0:3];
        wr_regs(8'h00, 1, '{8'h33, 8'h00, 8'h00, 8'h00}, "R8");
        rd_regs(8'h00, 1, 3'b000, d);
        chk("R8 id write ignored", d[0], 8'hA5);
    endtask

    task automatic t_mismatch();
        logic [7:0] d [0:3];
        logic ack;
        bus_start();
        send_byte(8'h56, 3'b000, ack); chk("R2 wrong addr no ack", 8'(ack), 8'h00);
        send_byte(8'h01, 3'b000, ack); chk("R2 ignored byte no ack", 8'(ack), 8'h00);
        send_byte(8'h77, 3'b000, ack); chk("R2 ignored data no ack", 8'(ack), 8'h00);
        bus_stop();
        rd_regs(8'h01, 1, 3'b000, d);
        chk("R2 scratch untouched", d[0], 8'h3C);
    endtask

    task automatic t_ram();
        logic [7:0] d [0:3];
        wr_regs(8'h04, 1, '{8'h0E, 8'h00, 8'h00, 8'h00}, "R6");
        wr_regs(8'h05, 3, '{8'h11, 8'h22, 8'h33, 8'h00}, "R6");
        rd_regs(8'h04, 1, 3'b000, d);
        chk("R6 pointer wrapped", d[0], 8'h01);
        wr_regs(8'h04, 1, '{8'h0E, 8'h00, 8'h00, 8'h00}, "R6");
        rd_regs(8'h05, 3, 3'b000, d);
        chk("R6 ram[14]", d[0], 8'h11);
        chk("R6 ram[15]", d[1], 8'h22);
        chk("R6 ram[0]", d[2], 8'h33);
    endtask

    task automatic t_ee();
        logic [7:0] d [0:3];
        wr_regs(8'h06, 1, '{8'h14, 8'h00, 8'h00, 8'h00}, "R7");
        wr_regs(8'h07, 3, '{8'hA0, 8'hA1, 8'hA2, 8'h00}, "R7");
        rd_regs(8'h06, 1, 3'b000, d);
        chk("R7 column wrap to next row", d[0], 8'h21);
        wr_regs(8'h06, 1, '{8'h35, 8'h00, 8'h00, 8'h00}, "R7");
        wr_regs(8'h07, 2, '{8'hB0, 8'hB1, 8'h00, 8'h00}, "R7");
        rd_regs(8'h06, 1, 3'b000, d);
        chk("R7 row wrap to zero", d[0], 8'h01);
        wr_regs(8'h06, 1, '{8'h14, 8'h00, 8'h00, 8'h00}, "R7");
        rd_regs(8'h07, 3, 3'b000, d);
        chk("R7 ee r1c4", d[0], 8'hA0);
        chk("R7 ee r1c5", d[1], 8'hA1);
        chk("R7 ee r2c0", d[2], 8'hA2);
        wr_regs(8'h06, 1, '{8'h35, 8'h00, 8'h00, 8'h00}, "R7");
        rd_regs(8'h07, 2, 3'b000, d);
        chk("R7 ee r3c5", d[0], 8'hB0);
        chk("R7 ee r0c0", d[1], 8'hB1);
    endtask

    task automatic t_events();
        logic [7:0] d [0:3];
        ev = 3'b101; tick(1); ev = 3'b000; tick(1);
        chk("R10 event raises int", 8'(int_o), 8'h01);
        wr_regs(8'h03, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R8");
        chk("R8 status write ignored", 8'(int_o), 8'h01);
        wr_regs(8'h02, 1, '{8'h01, 8'h00, 8'h00, 8'h00}, "R9");
        rd_regs(8'h03, 1, 3'b000, d);
        chk("R9 R10 status bits", d[0], 8'h0D);
        chk("R11 read clears int", 8'(int_o), 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d [0:3];
        ev = 3'b010; tick(1); ev = 3'b000; tick(1);
        rd_regs(8'h03, 1, 3'b001, d);
        chk("R11 returned pre-clear value", d[0], 8'h02);
        chk("R11 same-cycle event keeps int", 8'(int_o), 8'h01);
        rd_regs(8'h03, 1, 3'b000, d);
        chk("R11 only new event left", d[0], 8'h01);
        chk("R11 int cleared", 8'(int_o), 8'h00);
    endtask

    task automatic t_nack();
        logic [7:0] d0, d1;
        logic ack;
        bus_start();
        send_byte(AW, 3'b000, ack);
        send_byte(8'h01, 3'b000, ack);
        bus_start();
        send_byte(AR, 3'b000, ack);
        recv_byte(d0, 1'b1);
        recv_byte(d1, 1'b1);
        bus_stop();
        chk("R12 last byte", d0, 8'h3C);
        chk("R12 silent after nack", d1, 8'hFF);
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write_burst();
        t_read_last_index();
        t_read_only_id();
        t_mismatch();
        t_ram();
        t_ee();
        t_events();
        t_same_cycle();
        t_nack();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule